// File: doc/BRIEF.md
# Dual-Operand Pixel ALU

This block applies a per-pixel arithmetic or logic operation to two grey-scale pixel streams, A and B, in an image pipeline. Pixels are 9-bit two's complement. The code 9'h100, the value that would otherwise mean -256, is reserved to mean negative infinity, the value that marks an undefined pixel. A 9-bit constant can replace B as the second operand. A 4-bit opcode selects one of sixteen operations: signed minimum or maximum, a pass-through of one stream, subtraction or addition against B or against the constant, and two pass-through modes that also search the frame for the smallest or largest A pixel.

Each valid input beat produces one result pixel one clock later. The search result is held in a 9-bit register that can be read at the ports. A start-of-frame pulse starts a new search. One instance, the one ahead of the morphology stage, is normally built with the search disabled by a parameter. The other, after the morphology stage, keeps it.

Top module: `pixalu_core`

## Requirements
- R1: Pixels are 9-bit two's complement and 9'h100 means negative infinity. A sum or difference of two finite operands saturates to the range -255..+255 (9'h101..9'h0FF) and never yields 9'h100.
- R2: `outValid` is `inValid` delayed by one clock. `outPix` takes a new value only after a valid beat and holds it otherwise. After reset both outputs and `extremeVal` are zero.
- R3: The opcode is `ctrlByte[7:4]` and the low nibble is ignored. Code 0 outputs the signed minimum of A and B. Code 1 outputs the signed maximum. Negative infinity is the smallest value.
- R4: Codes 2 and 6 output A unchanged. Codes 3 and 7 output B unchanged.
- R5: Code 8 outputs A-B, or negative infinity when B is negative infinity. Code 12 (4'hC) outputs A-B, or A when B is negative infinity.
- R6: The constant K is `{constMsb, constByte}`. Code 9 outputs A-K, or negative infinity when K is negative infinity. Code 13 (4'hD) outputs A-K, or A when K is negative infinity.
- R7: Codes 10 and 14 output A+B. Codes 11 and 15 output A+K. If the added operand is negative infinity, the output is negative infinity.
- R8: For any code from 8 to 15, an A pixel of negative infinity gives a result of negative infinity.
- R9: Codes 4 and 5 output A. On each valid beat they fold A into `extremeVal`, taking the signed minimum for code 4 and the signed maximum for code 5. The first such beat after reset or after a start-of-frame pulse loads A directly. A start-of-frame pulse on that same beat counts as that first beat.
- R10: A start-of-frame pulse without a search beat sets `extremeVal` to 0 on the next clock. `extremeVal` does not change on any other cycle that lacks a search beat.
- R11: With `HAS_SEARCH` at 0, codes 4 and 5 output A and `extremeVal` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input beat valid |
| frameStart | input | 1 | Start-of-frame pulse |
| ctrlByte | input | 8 | Control byte; opcode in bits 7:4 |
| constByte | input | 8 | Constant, low eight bits |
| constMsb | input | 1 | Constant, sign bit (bit 8) |
| pixA | input | 9 | Pixel stream A |
| pixB | input | 9 | Pixel stream B |
| outValid | output | 1 | Result valid |
| outPix | output | 9 | Result pixel |
| extremeVal | output | 9 | Frame-wide search result |

## Verification
The bench aims at the negative-infinity code from every side. A subtraction that ignored the keep-A variant would output 9'h100 where A is expected. A design that let an infinite constant through as -256 would wrap to a large positive result instead of 9'h100. Saturation cases push sums past +255 and below -255. A missing clamp shows up as a wrapped value, or as a spurious 9'h100 from a difference of exactly -256. For the search register, the bench covers the first beat after a start-of-frame pulse and a pulse with no beat. It also covers beats with other opcodes between search beats. A design that compared against a stale value, or updated on non-search beats, would report the wrong extreme.

// File: rtl/pixalu_pkg.sv
package pixalu_pkg;

  typedef enum logic [2:0] {
    SEL_MIN,
    SEL_MAX,
    SEL_A,
    SEL_B,
    SEL_SUB,
    SEL_ADD
  } resSel_e;

  // strobes handed from the decoder to the datapath
  typedef struct packed {
    logic    beat;        // qualified input beat
    logic    frameStart;  // start-of-frame pulse
    resSel_e sel;         // result source
    logic    useConst;    // second operand is the constant
    logic    infKeepsA;   // infinite subtrahend returns A
    logic    trackEn;     // beat feeds the frame search
    logic    trackMax;    // search for maximum (else minimum)
  } aluStrobes_t;

endpackage

// File: rtl/pixalu_ctrl.sv
module pixalu_ctrl
  import pixalu_pkg::*;
#(
  parameter int OP_W       = 4,
  parameter bit HAS_SEARCH = 1'b1
) (
  input  logic            inValid,
  input  logic            frameStart,
  input  logic [OP_W-1:0] opcode,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes            = '0;
    strobes.beat       = inValid;
    strobes.frameStart = frameStart;
    strobes.sel        = SEL_A;
    if (opcode[OP_W-1]) begin
      // upper half: arithmetic
      strobes.sel       = opcode[1] ? SEL_ADD : SEL_SUB;
      strobes.useConst  = opcode[0];
      strobes.infKeepsA = opcode[2] & ~opcode[1];
    end else begin
      case (opcode[2:0])
        3'd0:    strobes.sel = SEL_MIN;
        3'd1:    strobes.sel = SEL_MAX;
        3'd3,
        3'd7:    strobes.sel = SEL_B;
        3'd4,
        3'd5: begin
          strobes.sel      = SEL_A;
          strobes.trackEn  = HAS_SEARCH;
          strobes.trackMax = opcode[0];
        end
        default: strobes.sel = SEL_A;
      endcase
    end
  end

endmodule

// File: rtl/pixalu_dp.sv
module pixalu_dp
  import pixalu_pkg::*;
#(
  parameter int PIX_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  aluStrobes_t      strobes,
  input  logic [PIX_W-1:0] pixA,
  input  logic [PIX_W-1:0] pixB,
  input  logic [PIX_W-1:0] constVal,
  output logic             outValid,
  output logic [PIX_W-1:0] outPix,
  output logic [PIX_W-1:0] extremeVal
);

  localparam int EXT_W = PIX_W + 2;
  localparam logic [PIX_W-1:0] NEG_INF = {1'b1, {(PIX_W-1){1'b0}}};
  localparam logic signed [EXT_W-1:0] SAT_HI = EXT_W'((2 ** (PIX_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] SAT_LO = -SAT_HI;

  logic [PIX_W-1:0] operand;
  logic signed [EXT_W-1:0] aWide, oWide, sumWide, diffWide;
  logic aInf, oInf;
  logic [PIX_W-1:0] result;
  logic fresh;

  function automatic logic [PIX_W-1:0] clampPix(input logic signed [EXT_W-1:0] v);
    logic signed [EXT_W-1:0] c;
    if (v > SAT_HI)      c = SAT_HI;
    else if (v < SAT_LO) c = SAT_LO;
    else                 c = v;
    return c[PIX_W-1:0];
  endfunction

  assign operand  = strobes.useConst ? constVal : pixB;
  assign aInf     = (pixA == NEG_INF);
  assign oInf     = (operand == NEG_INF);
  assign aWide    = EXT_W'($signed(pixA));
  assign oWide    = EXT_W'($signed(operand));
  assign sumWide  = aWide + oWide;
  assign diffWide = aWide - oWide;

  always_comb begin
    case (strobes.sel)
      SEL_MIN: result = ($signed(pixA) < $signed(pixB)) ? pixA : pixB;
      SEL_MAX: result = ($signed(pixA) > $signed(pixB)) ? pixA : pixB;
      SEL_B:   result = pixB;
      SEL_SUB: begin
        if (aInf)      result = NEG_INF;
        else if (oInf) result = strobes.infKeepsA ? pixA : NEG_INF;
        else           result = clampPix(diffWide);
      end
      SEL_ADD: result = (aInf || oInf) ? NEG_INF : clampPix(sumWide);
      default: result = pixA;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= strobes.beat;
      if (strobes.beat) outPix <= result;
    end
  end

  // frame-wide extreme search
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extremeVal <= '0;
      fresh      <= 1'b1;
    end else if (strobes.beat && strobes.trackEn) begin
      fresh <= 1'b0;
      if (fresh || strobes.frameStart)
        extremeVal <= pixA;
      else if (strobes.trackMax ? ($signed(pixA) > $signed(extremeVal))
                                : ($signed(pixA) < $signed(extremeVal)))
        extremeVal <= pixA;
    end else if (strobes.frameStart) begin
      extremeVal <= '0;
      fresh      <= 1'b1;
    end
  end

endmodule

// File: rtl/pixalu_core.sv
module pixalu_core
  import pixalu_pkg::*;
#(
  parameter int PIX_W      = 9,
  parameter int OP_W       = 4,
  parameter int CTRL_W     = 8,
  parameter bit HAS_SEARCH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              frameStart,
  input  logic [CTRL_W-1:0] ctrlByte,
  input  logic [PIX_W-2:0]  constByte,
  input  logic              constMsb,
  input  logic [PIX_W-1:0]  pixA,
  input  logic [PIX_W-1:0]  pixB,
  output logic              outValid,
  output logic [PIX_W-1:0]  outPix,
  output logic [PIX_W-1:0]  extremeVal
);

  localparam int FREE_W = CTRL_W - OP_W;

  aluStrobes_t      strobes;
  logic [OP_W-1:0]  opcode;
  logic [PIX_W-1:0] constVal;
  logic             unusedCtrlBits;

  assign opcode         = ctrlByte[CTRL_W-1 -: OP_W];
  assign unusedCtrlBits = ^ctrlByte[FREE_W-1:0];
  assign constVal       = {constMsb, constByte};

  pixalu_ctrl #(
    .OP_W       (OP_W),
    .HAS_SEARCH (HAS_SEARCH)
  ) u_ctrl (
    .inValid    (inValid),
    .frameStart (frameStart),
    .opcode     (opcode),
    .strobes    (strobes)
  );

  pixalu_dp #(
    .PIX_W (PIX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .pixA       (pixA),
    .pixB       (pixB),
    .constVal   (constVal),
    .outValid   (outValid),
    .outPix     (outPix),
    .extremeVal (extremeVal)
  );

endmodule

// File: rtl/pixalu_chk.sv
module pixalu_chk #(
  parameter bit HAS_SEARCH = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       frameStart,
  input logic [7:0] ctrlByte,
  input logic [7:0] constByte,
  input logic       constMsb,
  input logic [8:0] pixA,
  input logic [8:0] pixB,
  input logic       outValid,
  input logic [8:0] outPix,
  input logic [8:0] extremeVal
);

  localparam logic [8:0] NEG_INF = 9'h100;

  logic [3:0] op;
  logic [8:0] opnd;
  logic       srchBeat;

  assign op       = ctrlByte[7:4];
  assign opnd     = op[0] ? {constMsb, constByte} : pixB;
  assign srchBeat = inValid && (op == 4'd4 || op == 4'd5);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(outPix)));
  p_no_fake_inf_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op[3] && pixA != NEG_INF && opnd != NEG_INF) |=> outPix != NEG_INF);
  p_copy_a_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (op == 4'd2 || op == 4'd6)) |=> outPix == $past(pixA));
  p_sub_inf_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op == 4'd8 && pixB == NEG_INF) |=> outPix == NEG_INF);
  p_a_inf_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op[3] && pixA == NEG_INF) |=> outPix == NEG_INF);
  p_min_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SEARCH && inValid && op == 4'd4) |=> $signed(extremeVal) <= $signed($past(pixA)));
  p_max_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SEARCH && inValid && op == 4'd5) |=> $signed(extremeVal) >= $signed($past(pixA)));
  p_ext_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!srchBeat && !frameStart) |=> $stable(extremeVal));
  p_sof_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !srchBeat) |=> extremeVal == 9'd0);

endmodule

bind pixalu_core pixalu_chk #(.HAS_SEARCH(HAS_SEARCH)) u_chk (.*);

// File: tb/pixalu_core_bench.sv
module pixalu_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] NEG = 9'h100;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       frameStart = 1'b0;
  logic [7:0] ctrlByte = '0;
  logic [7:0] constByte = '0;
  logic       constMsb = 1'b0;
  logic [8:0] pixA = '0;
  logic [8:0] pixB = '0;
  logic       outValid, outValidN;
  logic [8:0] outPix, outPixN, extremeVal, extremeValN;

  int checks = 0;
  int failures = 0;

  // reference state
  logic       expValid = 1'b0;
  logic [8:0] expPix = '0;
  logic [8:0] expExt = '0;
  bit         expFresh = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pixalu_core u_pixalu_core (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .ctrlByte(ctrlByte), .constByte(constByte), .constMsb(constMsb),
    .pixA(pixA), .pixB(pixB), .outValid(outValid), .outPix(outPix),
    .extremeVal(extremeVal)
  );

  pixalu_core #(.HAS_SEARCH(1'b0)) u_pixalu_core_nosearch (
    .clk(clk), .rstN(rstN), .inValid(inValid), .frameStart(frameStart),
    .ctrlByte(ctrlByte), .constByte(constByte), .constMsb(constMsb),
    .pixA(pixA), .pixB(pixB), .outValid(outValidN), .outPix(outPixN),
    .extremeVal(extremeValN)
  );

  function automatic int toInt(logic [8:0] p);
    return p[8] ? int'(p) - 512 : int'(p);
  endfunction

  function automatic logic [8:0] px(int v);
    logic [31:0] w = v;
    return w[8:0];
  endfunction

  function automatic logic [8:0] refOp(int op, logic [8:0] a, logic [8:0] b, logic [8:0] k);
    int ai = toInt(a);
    int bi = toInt(b);
    logic [8:0] o;
    int r;
    bit isAdd, keepA;
    case (op)
      0: return (ai < bi) ? a : b;
      1: return (ai > bi) ? a : b;
      2, 4, 5, 6: return a;
      3, 7: return b;
      default: begin
        o     = (op % 2 == 1) ? k : b;
        isAdd = (op == 10 || op == 11 || op == 14 || op == 15);
        keepA = (op == 12 || op == 13);
        if (a == NEG) return NEG;
        if (o == NEG) return (!isAdd && keepA) ? a : NEG;
        r = isAdd ? ai + toInt(o) : ai - toInt(o);
        if (r > 255) r = 255;
        if (r < -255) r = -255;
        return px(r);
      end
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit sof, int op, logic [8:0] a, logic [8:0] b,
                      logic [8:0] k);
    @(negedge clk);
    inValid    = v;
    frameStart = sof;
    ctrlByte   = {op[3:0], 4'hA};
    constByte  = k[7:0];
    constMsb   = k[8];
    pixA       = a;
    pixB       = b;
    expValid   = v;
    if (v) expPix = refOp(op, a, b, k);
    if (v && (op == 4 || op == 5)) begin
      if (expFresh || sof) expExt = a;
      else if (op == 5 && toInt(a) > toInt(expExt)) expExt = a;
      else if (op == 4 && toInt(a) < toInt(expExt)) expExt = a;
      expFresh = 1'b0;
    end else if (sof) begin
      expExt   = '0;
      expFresh = 1'b1;
    end
    @(posedge clk);
    #2;
    check(tag, "outValid", int'(outValid), int'(expValid));
    check(tag, "outPix", int'(outPix), int'(expPix));
    check(tag, "extremeVal", int'(extremeVal), int'(expExt));
    check("R11", "nosearch outPix", int'(outPixN), int'(expPix));
    check("R11", "nosearch extremeVal", int'(extremeValN), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed = 7;
    repeat (3) @(posedge clk);
    #2;
    check("R2", "reset outValid", int'(outValid), 0);
    check("R2", "reset outPix", int'(outPix), 0);
    check("R10", "reset extremeVal", int'(extremeVal), 0);
    @(negedge clk);
    rstN = 1'b1;

    // R3 min/max, low nibble of ctrlByte is junk
    step("R3", 1, 0, 0, px(-3), px(7), 0);
    step("R3", 1, 0, 1, px(-3), px(7), 0);
    step("R3", 1, 0, 0, NEG, px(5), 0);
    step("R3", 1, 0, 1, NEG, px(5), 0);
    // R4 copies
    step("R4", 1, 0, 2, px(11), px(22), 0);
    step("R4", 1, 0, 3, px(11), px(22), 0);
    step("R4", 1, 0, 6, px(-40), px(41), 0);
    step("R4", 1, 0, 7, px(-40), NEG, 0);
    // R2 idle hold
    step("R2", 0, 0, 1, px(99), px(98), 0);
    step("R2", 0, 0, 10, px(1), px(2), 0);
    // R5 subtraction against B
    step("R5", 1, 0, 8, px(10), px(3), 0);
    step("R5", 1, 0, 8, px(10), NEG, 0);
    step("R5", 1, 0, 12, px(10), NEG, 0);
    step("R5", 1, 0, 12, px(5), px(9), 0);
    // R6 subtraction against the constant
    step("R6", 1, 0, 9, px(50), px(1), px(20));
    step("R6", 1, 0, 9, px(50), px(1), NEG);
    step("R6", 1, 0, 13, px(50), px(1), NEG);
    step("R6", 1, 0, 13, px(50), px(1), px(-5));
    // R7 addition
    step("R7", 1, 0, 10, px(100), px(27), px(3));
    step("R7", 1, 0, 11, px(100), px(27), px(-130));
    step("R7", 1, 0, 14, px(100), NEG, 0);
    step("R7", 1, 0, 15, px(100), 0, NEG);
    // R1 saturation
    step("R1", 1, 0, 10, px(200), px(100), 0);
    step("R1", 1, 0, 9, px(-200), 0, px(100));
    step("R1", 1, 0, 14, px(-255), px(-255), 0);
    step("R1", 1, 0, 8, px(-1), px(255), 0);
    // R8 infinite A
    step("R8", 1, 0, 8, NEG, px(4), 0);
    step("R8", 1, 0, 13, NEG, 0, NEG);
    step("R8", 1, 0, 11, NEG, 0, px(9));
    // R9 search
    step("R9", 1, 1, 4, px(10), 0, 0);
    step("R9", 1, 0, 4, px(-20), 0, 0);
    step("R9", 1, 0, 4, px(30), 0, 0);
    step("R10", 1, 0, 0, px(-100), px(-100), 0);
    step("R10", 0, 0, 4, px(-120), 0, 0);
    step("R9", 1, 1, 5, px(3), 0, 0);
    step("R9", 1, 0, 5, px(90), 0, 0);
    step("R9", 1, 0, 5, NEG, 0, 0);
    // R10 start-of-frame alone clears, next search beat loads
    step("R10", 0, 1, 5, px(1), 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0);
    step("R9", 1, 0, 4, px(77), 0, 0);
    step("R9", 1, 0, 4, px(78), 0, 0);

    // mixed stream over all opcodes
    for (int i = 0; i < 300; i++) begin
      int op, a, b, k;
      seed = seed * 1103515245 + 12345;
      op = (seed >>> 8) & 15;
      a  = (seed >>> 12) & 511;
      seed = seed * 1103515245 + 12345;
      b  = (seed >>> 9) & 511;
      k  = (seed >>> 18) & 511;
      step("R1", (i % 5) != 3, (i % 37) == 0, op, px(a), px(b), px(k));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule